// File: doc/BRIEF.md
# Switched-Capacitor Boost Inverter Vector Sequencer

This block drives the four switches of a boost inverter that uses a switched capacitor to raise the dc-link voltage. It steps through a fixed, symmetric sequence of eleven switch states in each sampling period. The length of each state comes from three dwell-time inputs: total zero-vector time, charge-side active time and discharge-side active time. Four 8-bit fractions set where each dwell time falls inside the period.

Setting the fractions picks the modulation flavour at run time, without a mode input:
- All four fractions at mid-scale give regular symmetric SVPWM.
- A zero-split fraction of 0 puts all zero time in the high zero state, which clamps to the upper rail (DPWMMAX-like).
- A zero-split fraction of full scale puts all zero time in the low zero state (DPWMMIN-like).

The block samples its inputs once per period, on the clock edge that starts the period. It emits a one-cycle strobe on that same cycle, so a controller can update the dwell times and fractions for the next period.

Top module: `scsv_seq_gen`

## Requirements
- R1: `sw_state` bits are [3] = capacitor switch, [2] = leg A, [1] = leg B, [0] = leg C. Segment k (0..10) drives, in order: 0000, 1000, 1001, 1101, 1100, 1110, 1100, 1101, 1001, 1000, 0000. When every segment of a period has a nonzero length, each change of `sw_state` inside the period flips exactly one bit.
- R2: A fraction f scales a time t as part(t,f) = (t·(f + f[7])) >> 8. So f = 255 gives t and f = 0 gives 0.
- R3: Let Z' be the effective zero time. The low zero time is zlo = part(Z', frac_zsplit) and goes to segments 0 and 10. The rest, Z' − zlo, goes to segment 5 (1110).
- R4: Segment 0 lasts part(zlo, frac_zhead) cycles. Segment 10 lasts the rest of zlo, so any rounding loss stays inside the period.
- R5: The charge time C is split as h = part(C, frac_chg) and g = C − h. Segment 1 lasts h>>1, segment 3 lasts h − (h>>1), segment 7 lasts g − (g>>1) and segment 9 lasts g>>1.
- R6: The discharge time D is split the same way with frac_dis, as k and m = D − k. Segment 2 lasts k>>1, segment 4 lasts k − (k>>1), segment 6 lasts m − (m>>1) and segment 8 lasts m>>1.
- R7: A period lasts Z' + C + D cycles. `period_start` is high in the first cycle of each period and low in every other cycle.
- R8: A segment of length zero never appears on `sw_state`. The sequence moves straight on to the next nonzero segment, with no extra cycle.
- R9: When D is nonzero, Z' = max(zero_dwell, MIN_ZERO), with MIN_ZERO = 4 by default. When D is zero, Z' = zero_dwell.
- R10: With D = 0 the discharge states 1001 and 1100 never appear, which is plain two-level operation.
- R11: All dwell and fraction inputs are sampled only on the edge that starts a period. A change made mid-period first affects the next period.
- R12: While `rst` is high, `sw_state` is 0000 and `period_start` is low. The first period begins on the first clock edge at which `rst` is low.
- R13: If all segment lengths are zero, each period is one cycle of 0000, and `period_start` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_dwell | input | TW | Total zero-vector time, in cycles |
| chg_dwell | input | TW | Charge-side active time, in cycles |
| dis_dwell | input | TW | Discharge-side active time, in cycles |
| frac_zsplit | input | FW | Low/high zero-state split |
| frac_zhead | input | FW | Head/tail split of the low zero time |
| frac_chg | input | FW | First/second half split of the charge time |
| frac_dis | input | FW | First/second half split of the discharge time |
| sw_state | output | 4 | Switch vector {cap, A, B, C} |
| period_start | output | 1 | High in the first cycle of each period |

## Verification
The assertions take for granted that the inputs are meaningful only when the period begins, and that Z' + C + D does not exceed what one period can count. Under that assumption, they check the segment lengths the block has captured, not the live inputs. The stimulus changes inputs only at the negative edge, and mostly in the last cycle of a period. The one deliberate exception is a mid-period change made to exercise R11. The dwell values stay small, so the sums stay far below 2^TW. One vector holds its zero time below MIN_ZERO with discharge active, and another does so with discharge idle, to separate the two cases of R9.

// File: rtl/scsv_pkg.sv
package scsv_pkg;
   localparam int NSEG  = 11;
   localparam int SEG_W = $clog2(NSEG);

   // switch code per segment: {cap, leg A, leg B, leg C}
   function automatic logic [3:0] seg_code(input logic [SEG_W-1:0] idx);
      case (idx)
         4'd1, 4'd9: seg_code = 4'b1000;
         4'd2, 4'd8: seg_code = 4'b1001;
         4'd3, 4'd7: seg_code = 4'b1101;
         4'd4, 4'd6: seg_code = 4'b1100;
         4'd5:       seg_code = 4'b1110;
         default:    seg_code = 4'b0000;
      endcase
   endfunction
endpackage

// File: rtl/scsv_dwell_split.sv
module scsv_dwell_split
   import scsv_pkg::*;
#(
   parameter int TW       = 10,
   parameter int FW       = 8,
   parameter int MIN_ZERO = 4
) (
   input  logic [TW-1:0]            zero_t,
   input  logic [TW-1:0]            chg_t,
   input  logic [TW-1:0]            dis_t,
   input  logic [FW-1:0]            f_zsplit,
   input  logic [FW-1:0]            f_zhead,
   input  logic [FW-1:0]            f_chg,
   input  logic [FW-1:0]            f_dis,
   output logic [NSEG-1:0][TW-1:0]  lens
);
   localparam int PW = TW + FW + 1;

   // scale t by f where all-ones means unity
   function automatic logic [TW-1:0] part(input logic [TW-1:0] t, input logic [FW-1:0] f);
      logic [PW-1:0] p;
      p = PW'(t) * PW'({1'b0, f} + (FW+1)'(f[FW-1]));
      return TW'(p >> FW);
   endfunction

   logic [TW-1:0] zeff, zlo, zhi, zh, zt, ch1, ch2, dh1, dh2;

   generate
      if (MIN_ZERO > 0) begin : g_floor
         assign zeff = (dis_t != '0 && zero_t < TW'(MIN_ZERO)) ? TW'(MIN_ZERO) : zero_t;
      end else begin : g_plain
         assign zeff = zero_t;
      end
   endgenerate

   always_comb begin
      zlo = part(zeff, f_zsplit);
      zhi = zeff - zlo;
      zh  = part(zlo, f_zhead);
      zt  = zlo - zh;
      ch1 = part(chg_t, f_chg);
      ch2 = chg_t - ch1;
      dh1 = part(dis_t, f_dis);
      dh2 = dis_t - dh1;
      lens[0]  = zh;
      lens[1]  = ch1 >> 1;
      lens[2]  = dh1 >> 1;
      lens[3]  = ch1 - (ch1 >> 1);
      lens[4]  = dh1 - (dh1 >> 1);
      lens[5]  = zhi;
      lens[6]  = dh2 - (dh2 >> 1);
      lens[7]  = ch2 - (ch2 >> 1);
      lens[8]  = dh2 >> 1;
      lens[9]  = ch2 >> 1;
      lens[10] = zt;
   end
endmodule

// File: rtl/scsv_seq_core.sv
module scsv_seq_core
   import scsv_pkg::*;
#(
   parameter int TW = 10
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NSEG-1:0][TW-1:0]  lens_in,
   output logic [NSEG-1:0][TW-1:0]  lens_q,
   output logic [SEG_W-1:0]         seg_q,
   output logic                     strobe_q
);
   logic [TW-1:0]    cnt_q;
   logic             pend_q;
   logic             nxt_found, first_found, period_load;
   logic [SEG_W-1:0] nxt_idx, first_idx;

   // lowest nonzero segment above the current one, and lowest in the new period
   always_comb begin
      nxt_found   = 1'b0;
      nxt_idx     = '0;
      first_found = 1'b0;
      first_idx   = '0;
      for (int k = NSEG - 1; k >= 0; k--) begin
         if (SEG_W'(k) > seg_q && lens_q[k] != '0) begin
            nxt_found = 1'b1;
            nxt_idx   = SEG_W'(k);
         end
         if (lens_in[k] != '0) begin
            first_found = 1'b1;
            first_idx   = SEG_W'(k);
         end
      end
      period_load = pend_q || (cnt_q == '0 && !nxt_found);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q   <= 1'b1;
         seg_q    <= '0;
         cnt_q    <= '0;
         strobe_q <= 1'b0;
         lens_q   <= '0;
      end else if (period_load) begin
         pend_q   <= 1'b0;
         lens_q   <= lens_in;
         seg_q    <= first_found ? first_idx : '0;
         cnt_q    <= first_found ? lens_in[first_idx] - TW'(1) : '0;
         strobe_q <= 1'b1;
      end else if (cnt_q == '0) begin
         seg_q    <= nxt_idx;
         cnt_q    <= lens_q[nxt_idx] - TW'(1);
         strobe_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_q - TW'(1);
         strobe_q <= 1'b0;
      end
   end
endmodule

// File: rtl/scsv_seq_gen.sv
module scsv_seq_gen
   import scsv_pkg::*;
#(
   parameter int TW       = 10,
   parameter int FW       = 8,
   parameter int MIN_ZERO = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [TW-1:0] zero_dwell,
   input  logic [TW-1:0] chg_dwell,
   input  logic [TW-1:0] dis_dwell,
   input  logic [FW-1:0] frac_zsplit,
   input  logic [FW-1:0] frac_zhead,
   input  logic [FW-1:0] frac_chg,
   input  logic [FW-1:0] frac_dis,
   output logic [3:0]    sw_state,
   output logic          period_start
);
   generate
      if (TW < 2) begin : g_bad_tw
         $error("TW must be at least 2");
      end
      if (FW < 2) begin : g_bad_fw
         $error("FW must be at least 2");
      end
      if (MIN_ZERO < 0 || MIN_ZERO >= (1 << TW)) begin : g_bad_minz
         $error("MIN_ZERO must fit in TW bits");
      end
   endgenerate

   logic [NSEG-1:0][TW-1:0] new_lens, cur_lens;
   logic [SEG_W-1:0]        seg_idx;

   scsv_dwell_split #(.TW(TW), .FW(FW), .MIN_ZERO(MIN_ZERO)) u_split (
      .zero_t   (zero_dwell),
      .chg_t    (chg_dwell),
      .dis_t    (dis_dwell),
      .f_zsplit (frac_zsplit),
      .f_zhead  (frac_zhead),
      .f_chg    (frac_chg),
      .f_dis    (frac_dis),
      .lens     (new_lens)
   );

   scsv_seq_core #(.TW(TW)) u_core (
      .clk      (clk),
      .rst      (rst),
      .lens_in  (new_lens),
      .lens_q   (cur_lens),
      .seg_q    (seg_idx),
      .strobe_q (period_start)
   );

   assign sw_state = seg_code(seg_idx);
endmodule

// File: rtl/scsv_seq_gen_chk.sv
module scsv_seq_gen_chk
   import scsv_pkg::*;
#(
   parameter int TW = 10
) (
   input logic                     clk,
   input logic                     rst,
   input logic [3:0]               sw_state,
   input logic                     period_start,
   input logic [NSEG-1:0][TW-1:0]  cur_lens
);
   logic            all_nz, no_dis;
   logic [TW+3:0]   total;

   always_comb begin
      all_nz = 1'b1;
      total  = '0;
      for (int k = 0; k < NSEG; k++) begin
         if (cur_lens[k] == '0) all_nz = 1'b0;
         total = total + (TW+4)'(cur_lens[k]);
      end
      no_dis = (cur_lens[2] == '0) && (cur_lens[4] == '0) &&
               (cur_lens[6] == '0) && (cur_lens[8] == '0);
   end

   // R1: only the six codes of the sequence are ever driven
   a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
      (sw_state == 4'b0000 || sw_state == 4'b1000 || sw_state == 4'b1001 ||
       sw_state == 4'b1101 || sw_state == 4'b1100 || sw_state == 4'b1110));

   // R1: one bit flips per step when no segment is skipped
   a_r1_one_bit_step: assert property (@(posedge clk) disable iff (rst)
      (all_nz && !period_start) |-> ($countones(sw_state ^ $past(sw_state)) <= 1));

   // R7: the strobe is a single cycle when the period is longer than one cycle
   a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
      (period_start && total > 1) |=> !period_start);

   // R10: no discharge state when the captured discharge time is zero
   a_r10_no_discharge: assert property (@(posedge clk) disable iff (rst)
      no_dis |-> (sw_state != 4'b1001 && sw_state != 4'b1100));

   // R12: reset idles the outputs
   a_r12_reset_idle: assert property (@(posedge clk)
      rst |=> (sw_state == 4'b0000 && !period_start));
endmodule

bind scsv_seq_gen scsv_seq_gen_chk #(.TW(TW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .sw_state     (sw_state),
   .period_start (period_start),
   .cur_lens     (cur_lens)
);

// File: tb/tb_scsv_seq_gen.sv
module tb_scsv_seq_gen;
   localparam int TW = 10, FW = 8, MINZ = 4, NV = 7;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1;
   logic [TW-1:0] zd = '0, cd = '0, dd = '0;
   logic [FW-1:0] f0 = '0, f1 = '0, f2 = '0, f3 = '0;
   logic [3:0]    sw;
   logic          ps;

   scsv_seq_gen #(.TW(TW), .FW(FW), .MIN_ZERO(MINZ)) dut (
      .clk(clk), .rst(rst), .zero_dwell(zd), .chg_dwell(cd), .dis_dwell(dd),
      .frac_zsplit(f0), .frac_zhead(f1), .frac_chg(f2), .frac_dis(f3),
      .sw_state(sw), .period_start(ps)
   );

   // stimulus: zero, charge, discharge, four fractions; expected period length
   localparam int V_Z [NV] = '{20, 20, 12, 12,  2,   9, 2};
   localparam int V_C [NV] = '{16, 16, 10, 10,  8,   7, 8};
   localparam int V_D [NV] = '{ 0,  8,  6,  6,  4,   5, 0};
   localparam int V_F0[NV] = '{128,128,  0,255,128,  77,128};
   localparam int V_F1[NV] = '{128,128,128,128,128, 200,128};
   localparam int V_F2[NV] = '{128,128,128,128,128,  30,128};
   localparam int V_F3[NV] = '{128,128,128,128,128, 255,128};
   localparam int V_LEN[NV] = '{36, 44, 28, 28, 16, 21, 10};
   localparam string V_TAG[NV] = '{"R10 two-level", "R1 R5 R6 svpwm",
      "R3 R8 clamp-high", "R3 R8 clamp-low", "R9 min-zero",
      "R2 R4 odd fractions", "R9 no floor"};

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int part(input int t, input int f);
      return (t * (f + (f >= 128 ? 1 : 0))) / 256;
   endfunction

   function automatic logic [3:0] code(input int k);
      case (k)
         1, 9: return 4'b1000;
         2, 8: return 4'b1001;
         3, 7: return 4'b1101;
         4, 6: return 4'b1100;
         5:    return 4'b1110;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic set_in(input int v);
      zd = TW'(V_Z[v]); cd = TW'(V_C[v]); dd = TW'(V_D[v]);
      f0 = FW'(V_F0[v]); f1 = FW'(V_F1[v]); f2 = FW'(V_F2[v]); f3 = FW'(V_F3[v]);
   endtask

   task automatic set_zero();
      zd = '0; cd = '0; dd = '0; f0 = '0; f1 = '0; f2 = '0; f3 = '0;
   endtask

   // Called at the negedge before the period-start edge; ends at the last cycle's negedge.
   task automatic run_period(input int z, input int c, input int d, input int r0,
                             input int r1, input int r2, input int r3,
                             input string tag, input int exp_len, input int alt_at, input int alt_v);
      int len[11];
      int ze, zlo, h, g, k, m, cyc, tot;
      bit saw_dis;
      ze  = (d != 0 && z < MINZ) ? MINZ : z;
      zlo = part(ze, r0);
      h = part(c, r2); g = c - h; k = part(d, r3); m = d - k;
      len[0] = part(zlo, r1); len[10] = zlo - len[0]; len[5] = ze - zlo;
      len[1] = h / 2; len[3] = h - h / 2; len[7] = g - g / 2; len[9] = g / 2;
      len[2] = k / 2; len[4] = k - k / 2; len[6] = m - m / 2; len[8] = m / 2;
      tot = 0;
      for (int s = 0; s < 11; s++) tot += len[s];
      if (exp_len >= 0) chk(tot == exp_len, {tag, " R7 length"}, tot, exp_len);
      cyc = 0; saw_dis = 0;
      if (tot == 0) begin
         @(negedge clk);
         chk(sw == 4'b0000, {tag, " R13 state"}, int'(sw), 0);
         chk(ps == 1'b1, {tag, " R13 strobe"}, int'(ps), 1);
      end
      for (int s = 0; s < 11; s++) begin
         for (int j = 0; j < len[s]; j++) begin
            @(negedge clk);
            chk(sw == code(s), {tag, " R1 R8 state"}, int'(sw), int'(code(s)));
            chk(ps == (cyc == 0), {tag, " R7 strobe"}, int'(ps), int'(cyc == 0));
            if (sw == 4'b1001 || sw == 4'b1100) saw_dis = 1;
            cyc++;
            if (cyc == alt_at) set_in(alt_v);
         end
      end
      if (d == 0) chk(!saw_dis, {tag, " R10 no discharge"}, int'(saw_dis), 0);
   endtask

   task automatic run_vec(input int v, input int alt_at, input int alt_v);
      run_period(V_Z[v], V_C[v], V_D[v], V_F0[v], V_F1[v], V_F2[v], V_F3[v],
                 V_TAG[v], V_LEN[v], alt_at, alt_v);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      set_in(0);
      repeat (3) @(negedge clk);
      chk(sw == 4'b0000, "R12 reset state", int'(sw), 0);
      chk(ps == 1'b0, "R12 reset strobe", int'(ps), 0);
      rst = 1'b0;

      // table walk: new inputs set in the last cycle of each period
      for (int v = 0; v < NV; v++) begin
         set_in(v);
         run_vec(v, -1, 0);
      end

      // R11: mid-period change lands in the next period only
      set_in(1);
      run_vec(1, 5, 5);
      run_vec(5, -1, 0);

      // R13: all-zero lengths give one-cycle periods
      set_zero();
      run_period(0, 0, 0, 0, 0, 0, 0, "R13 empty", 0, -1, 0);
      run_period(0, 0, 0, 0, 0, 0, 0, "R13 empty again", 0, -1, 0);

      // R12: reset in mid-period, then restart from segment 0
      set_in(1);
      repeat (6) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(sw == 4'b0000, "R12 mid reset state", int'(sw), 0);
      chk(ps == 1'b0, "R12 mid reset strobe", int'(ps), 0);
      rst = 1'b0;
      run_vec(1, -1, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule